// File: doc/BRIEF.md
# Lockable Comparator Control Register

One 32-bit control and status word for a single analogue comparator channel. It sits on a simple register bus with address, write strobe, write data and combinational read data. The word holds the channel's configuration: enable, speed mode, inverting-input source, polarity, hysteresis level, blanking source and output routing. Every field also drives a dedicated output to the comparator datapath. A read returns the stored fields, a write-once lock flag and a synchronised live copy of the comparator's output.

The lock protects safety-relevant setups such as over-current trips from stray register writes or a runaway program. Software sets the lock together with its final configuration. From that point the whole word, lock included, ignores every bus write. Only the asynchronous reset releases it. The live output bit keeps following the comparator while the word is locked.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset the word reads 0x00000000, all configuration outputs are 0 and the lock is clear.
- R2: An unlocked write to the register address stores the fields at these positions: enable bit 0, mode bits 3:2, inverting-input select bits 6:4, output select bits 13:10, polarity bit 15, hysteresis bits 17:16, blanking select bits 20:18. From the next clock edge each field appears both on its output port and in the read word.
- R3: Every bit position that is not a field, the lock or the live bit (bits 29:21, 14, 9:7 and 1) reads 0, whatever was written there.
- R4: Writing 1 to bit 31 while unlocked sets the lock. The same write also stores all fields. Bit 31 reads back the lock state.
- R5: While the lock is set, every write is ignored: the fields, the outputs and the lock itself all stay unchanged.
- R6: Only the asynchronous reset clears the lock. After reset the word is writable again.
- R7: Bit 30 shows the comparator input after a two-flop synchroniser, so a change on `cmp_i` reads back after the second rising clock edge. A write to bit 30 has no effect. The live bit keeps updating while the word is locked.
- R8: A write to any other address leaves the register unchanged. A read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Bus word address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| cmp_i | input | 1 | Raw comparator output, asynchronous |
| en_o | output | 1 | Channel enable |
| mode_o | output | 2 | Speed/power mode |
| inm_sel_o | output | 3 | Inverting-input source |
| out_sel_o | output | 4 | Output routing select |
| pol_o | output | 1 | Output inversion |
| hyst_o | output | 2 | Hysteresis level |
| blank_sel_o | output | 3 | Blanking source select |

## Verification
The bench builds the block with ADDR_W = 6 and REG_ADDR = 0x24. The decoded address then has neighbours that differ from it in a single bit, so the bench can aim writes at 0x25 and 0x20 to show that the address match is exact. SYNC_STAGES stays at 2, so the bench can check the live bit both one edge after an input change, when it must not have moved yet, and two edges after it. The table of write vectors covers each field alone, all fields at once, and a word with only reserved bits set.

// File: rtl/cmpreg_pkg.sv
package cmpreg_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EN_B     = 0;
  localparam int unsigned MODE_LO  = 2;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned INSEL_LO = 4;
  localparam int unsigned INSEL_W  = 3;
  localparam int unsigned OSEL_LO  = 10;
  localparam int unsigned OSEL_W   = 4;
  localparam int unsigned POL_B    = 15;
  localparam int unsigned HYST_LO  = 16;
  localparam int unsigned HYST_W   = 2;
  localparam int unsigned BLANK_LO = 18;
  localparam int unsigned BLANK_W  = 3;
  localparam int unsigned LIVE_B   = 30;
  localparam int unsigned LOCK_B   = 31;

  typedef struct packed {
    logic [BLANK_W-1:0] blank;
    logic [HYST_W-1:0]  hyst;
    logic               pol;
    logic [OSEL_W-1:0]  osel;
    logic [INSEL_W-1:0] insel;
    logic [MODE_W-1:0]  mode;
    logic               en;
  } cfg_t;

  function automatic cfg_t cfg_decode(logic [REG_W-1:0] w);
    cfg_t c;
    logic unused_bits;
    unused_bits = ^{w[31:21], w[14], w[9:7], w[1]};
    c.en    = w[EN_B];
    c.mode  = w[MODE_LO +: MODE_W];
    c.insel = w[INSEL_LO +: INSEL_W];
    c.osel  = w[OSEL_LO +: OSEL_W];
    c.pol   = w[POL_B];
    c.hyst  = w[HYST_LO +: HYST_W];
    c.blank = w[BLANK_LO +: BLANK_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] word_encode(cfg_t c, logic lock, logic live);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_B]                 = c.en;
    w[MODE_LO +: MODE_W]    = c.mode;
    w[INSEL_LO +: INSEL_W]  = c.insel;
    w[OSEL_LO +: OSEL_W]    = c.osel;
    w[POL_B]                = c.pol;
    w[HYST_LO +: HYST_W]    = c.hyst;
    w[BLANK_LO +: BLANK_W]  = c.blank;
    w[LIVE_B]               = live;
    w[LOCK_B]               = lock;
    return w;
  endfunction
endpackage

// File: rtl/cmpreg_sync.sv
module cmpreg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d_i;
      end
      assign q_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
      end
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cmpreg_store.sv
module cmpreg_store
  import cmpreg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic             lock_o
);
  cfg_t cfg_q;
  logic lock_q;

  // lock gates the whole word, itself included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      cfg_q  <= cfg_decode(wdata_i);
      lock_q <= wdata_i[LOCK_B];
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/cmpreg_rdmux.sv
module cmpreg_rdmux
  import cmpreg_pkg::*;
(
  input  logic             hit_i,
  input  cfg_t             cfg_i,
  input  logic             lock_i,
  input  logic             live_i,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) rdata_o = word_encode(cfg_i, lock_i, live_i);
  end
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmpreg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_ADDR    = 32'h1C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                cmp_i,
  output logic                en_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [INSEL_W-1:0]  inm_sel_o,
  output logic [OSEL_W-1:0]   out_sel_o,
  output logic                pol_o,
  output logic [HYST_W-1:0]   hyst_o,
  output logic [BLANK_W-1:0]  blank_sel_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic hit_s;
  logic wr_s;
  logic lock_s;
  logic live_s;
  cfg_t cfg_s;

  assign hit_s = (addr_i == MY_ADDR);
  assign wr_s  = we_i && hit_s;

  cmpreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (live_s)
  );

  cmpreg_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_s),
    .wdata_i (wdata_i),
    .cfg_o   (cfg_s),
    .lock_o  (lock_s)
  );

  cmpreg_rdmux u_rdmux (
    .hit_i   (hit_s),
    .cfg_i   (cfg_s),
    .lock_i  (lock_s),
    .live_i  (live_s),
    .rdata_o (rdata_o)
  );

  assign en_o        = cfg_s.en;
  assign mode_o      = cfg_s.mode;
  assign inm_sel_o   = cfg_s.insel;
  assign out_sel_o   = cfg_s.osel;
  assign pol_o       = cfg_s.pol;
  assign hyst_o      = cfg_s.hyst;
  assign blank_sel_o = cfg_s.blank;
endmodule

module cmpreg_chk #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_ADDR    = 32'h1C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              cmp_i,
  input logic              lock_i,
  input logic [15:0]       cfg_flat_i
);
  logic       hit;
  logic [1:0] since_rst;
  assign hit = (addr_i == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (cfg_flat_i == 16'h0 && !lock_i);
    end
  end

  assert_write_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit && !lock_i) |=> cfg_flat_i == $past({wdata_i[20:15], wdata_i[13:10],
                                                      wdata_i[6:2], wdata_i[0]}));

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (rdata_o & 32'h3FE0_4382) == 32'h0);

  assert_lock_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit && !lock_i && wdata_i[31]) |=> lock_i);

  assert_lock_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> rdata_o[31] == lock_i);

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(cfg_flat_i));

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  assert_miss_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rdata_o == 32'h0);

  assert_miss_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> ($stable(cfg_flat_i) && $stable(lock_i)));

  generate
    if (SYNC_STAGES == 2) begin : g_live
      assert_live_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2 && hit) |-> rdata_o[30] == $past(cmp_i, 2));
    end
  endgenerate
endmodule

bind cmp_ctrl_reg cmpreg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .cmp_i      (cmp_i),
  .lock_i     (lock_s),
  .cfg_flat_i ({blank_sel_o, hyst_o, pol_o, out_sel_o, inm_sel_o, mode_o, en_o})
);

// File: tb/test_cmp_ctrl_reg.sv
`timescale 1ns/1ps
module test_cmp_ctrl_reg;
  localparam int unsigned AW   = 6;
  localparam logic [AW-1:0] RA = 6'h24;
  localparam int unsigned NVEC = 10;

  typedef struct packed {
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 32'h0000_0001},
    '{32'h0000_000C, 32'h0000_000C},
    '{32'h0000_0070, 32'h0000_0070},
    '{32'h0000_3C00, 32'h0000_3C00},
    '{32'h0000_8000, 32'h0000_8000},
    '{32'h0003_0000, 32'h0003_0000},
    '{32'h001C_0000, 32'h001C_0000},
    '{32'h7FE0_4382, 32'h0000_0000},
    '{32'h7FFF_FFFF, 32'h001F_BC7D},
    '{32'h0012_5A35, 32'h0012_1835}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          cmp_i = 1'b0;
  logic          en_o, pol_o;
  logic [1:0]    mode_o, hyst_o;
  logic [2:0]    inm_sel_o, blank_sel_o;
  logic [3:0]    out_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmp_ctrl_reg #(.ADDR_W(AW), .REG_ADDR(32'(RA)), .SYNC_STAGES(2)) i_cmp_ctrl_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cmp_i(cmp_i), .en_o(en_o), .mode_o(mode_o),
    .inm_sel_o(inm_sel_o), .out_sel_o(out_sel_o), .pol_o(pol_o), .hyst_o(hyst_o),
    .blank_sel_o(blank_sel_o)
  );

  function automatic logic [15:0] fields(logic [31:0] w);
    return {w[20:18], w[17:16], w[15], w[13:10], w[6:4], w[3:2], w[0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic chk_cfg(string req, logic [31:0] exp_word);
    chk(req, 32'({blank_sel_o, hyst_o, pol_o, out_sel_o, inm_sel_o, mode_o, en_o}),
        32'(fields(exp_word)));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rd(RA, r);
    chk("R1 reset word", r, 32'h0);
    chk_cfg("R1 reset outputs", 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: fields and reserved positions
    for (int i = 0; i < NVEC; i++) begin
      wr(RA, VECS[i].wd);
      rd(RA, r);
      chk("R2 R3 readback", r, VECS[i].ex);
      chk_cfg("R2 outputs", VECS[i].ex);
    end

    // R8: other addresses
    wr(RA, 32'h0000_0001);
    wr(RA ^ 6'h01, 32'h001F_BC7D);
    wr(RA & 6'h20, 32'h001F_BC7D);
    rd(RA, r);
    chk("R8 miss write ignored", r, 32'h0000_0001);
    chk_cfg("R8 miss write outputs", 32'h0000_0001);
    rd(RA ^ 6'h01, r);
    chk("R8 miss read zero", r, 32'h0);
    addr_i = RA;

    // R7: synchroniser latency
    @(negedge clk_i);
    cmp_i = 1'b1;
    @(negedge clk_i);
    rd(RA, r);
    chk("R7 one edge no change", 32'(r[30]), 32'h0);
    @(negedge clk_i);
    rd(RA, r);
    chk("R7 two edges live", r, 32'h4000_0001);
    cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    wr(RA, 32'h4000_0001);
    rd(RA, r);
    chk("R7 write to live bit ignored", r, 32'h0000_0001);

    // R4: lock with fields in same write
    wr(RA, 32'h8000_0005);
    rd(RA, r);
    chk("R4 lock and fields", r, 32'h8000_0005);
    chk_cfg("R4 outputs", 32'h8000_0005);

    // R5: frozen
    wr(RA, 32'h0000_0000);
    rd(RA, r);
    chk("R5 clear attempt ignored", r, 32'h8000_0005);
    wr(RA, 32'h7FFF_FFFF);
    rd(RA, r);
    chk("R5 field write ignored", r, 32'h8000_0005);
    chk_cfg("R5 outputs held", 32'h8000_0005);
    cmp_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(RA, r);
    chk("R7 live while locked", r, 32'hC000_0005);

    // R6: only reset unlocks
    cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    rd(RA, r);
    chk("R6 reset clears lock", r, 32'h0);
    chk_cfg("R6 reset outputs", 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr(RA, 32'h0000_0008);
    rd(RA, r);
    chk("R6 writable after reset", r, 32'h0000_0008);
    chk_cfg("R6 outputs after reset", 32'h0000_0008);

    done = 1'b1;
    summary();
  end
endmodule